// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block drives the four switches of a full bridge: a high-side and a low-side switch on leg A and on leg B. It does not vary pulse width. It shifts the switching instant of leg B against leg A, so the overlap during which power flows is set by when a trip arrives. An internal digital oscillator has a programmable charge phase and a fixed discharge phase. The discharge phase is the internal clock. Each rise of that clock flips a phase bit, so every drive toggles at half the oscillator rate, and the roles of the two legs alternate between half periods.

Each leg turns off its active switch first. It turns on the opposite switch only after that leg's own dead time has expired, which leaves room for zero-voltage transitions. Leg A changes sides on the internal clock. Leg B changes sides on the first accepted trip from the modulator or from the current limit. If no trip arrives in a half period, leg B changes sides on the clock together with leg A, which gives the largest overlap.

Top module: `psfb_gate_seq`

## Requirements
- R1: While reset is held, and after it until enable rises, all four drives and the clock indicator are low.
- R2: On the first clock edge that samples enable high, leg A low-side and leg B high-side switch on together, which starts a power interval.
- R3: The oscillator alternates two phases. The indicator is low for `chg_len_i` cycles (0 acts as 1), with the length sampled at the start of each charge phase. It is then high for `DIS_CYC` cycles.
- R4: A trip that is accepted at edge T switches off the active leg-B drive after edge T+1. The opposite leg-B drive switches on `dt_b_i` cycles later.
- R5: At the edge where the indicator rises, the phase bit flips. After the next edge the active leg-A drive is off. The opposite leg-A drive switches on `dt_a_i` cycles after that.
- R6: The dead times of leg A and leg B are independent. Each leg's gap equals its own count, sampled when that leg changes sides.
- R7: A dead-time count of 0 makes a leg turn off one drive and turn on the other on the same edge.
- R8: If no trip is accepted in a half period, leg B changes sides at the clock rise along with leg A.
- R9: The high and low drives of one leg are never both high in the same cycle.
- R10: Enable low forces all drives and the indicator low after one edge and resets the phase. Re-enabling starts again with leg A low-side and leg B high-side.
- R11: A trip is ignored in three cases: while either leg is still in its dead time, after a trip has already been taken in the current half period, and until the next clock rise.
- R12: In even half periods power flows through leg A low-side and leg B high-side. In odd half periods it flows through leg A high-side and leg B low-side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces all drives off |
| chg_len_i | input | CNT_W | Oscillator charge phase length in cycles |
| dt_a_i | input | DT_W | Leg A dead time in cycles |
| dt_b_i | input | DT_W | Leg B dead time in cycles |
| mod_trip_i | input | 1 | Modulator trip pulse |
| ilim_trip_i | input | 1 | Current-limit trip pulse |
| a_hi_o | output | 1 | Leg A high-side drive |
| a_lo_o | output | 1 | Leg A low-side drive |
| b_hi_o | output | 1 | Leg B high-side drive |
| b_lo_o | output | 1 | Leg B low-side drive |
| osc_clk_o | output | 1 | Internal clock indicator (discharge phase) |

## Verification
The hardest case to reach from the ports is the set of trips that must be dropped. These include a trip during leg B's own dead time, a second trip in the same half period, and a trip that lands inside leg A's dead time just after the clock rise. Each one leaves the drives exactly as they would have been without it.

The stimulus counts edges from the enable rise, so it knows where each window opens. It places single-cycle trip pulses inside each window. It then checks at the ports that leg B has not moved before the next clock rise.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  localparam int NUM_LEGS = 2;
  localparam int LEG_A    = 0;
  localparam int LEG_B    = 1;

  typedef enum logic {
    OSC_CHARGE    = 1'b0,
    OSC_DISCHARGE = 1'b1
  } osc_phase_e;

  typedef struct packed {
    logic sel;
    logic gap;
  } leg_state_t;

endpackage

// File: rtl/psfb_osc.sv
module psfb_osc
  import psfb_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DIS_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] chg_len_i,
  output logic             osc_clk_o,
  output logic             start_o
);

  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(DIS_CYC - 1);

  osc_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] chg_last;
  logic             cnt_zero;

  assign chg_last = (chg_len_i == '0) ? '0 : chg_len_i - 1'b1;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      ph_d  = OSC_CHARGE;
      cnt_d = chg_last;
    end else if (cnt_zero) begin
      if (ph_q == OSC_CHARGE) begin
        ph_d  = OSC_DISCHARGE;
        cnt_d = DIS_LAST;
      end else begin
        ph_d  = OSC_CHARGE;
        cnt_d = chg_last;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= OSC_CHARGE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign osc_clk_o = (ph_q == OSC_DISCHARGE);
  assign start_o   = en_i && (ph_q == OSC_CHARGE) && cnt_zero;

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg
  import psfb_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sel_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            drv0_o,
  output logic            drv1_o,
  output logic            sel_o,
  output logic            busy_o
);

  leg_state_t      st_q, st_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            dt_zero;
  logic            side_change;

  assign dt_zero     = (dt_i == '0);
  assign side_change = (sel_i != st_q.sel);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d.sel = 1'b0;
      st_d.gap = 1'b1;
      cnt_d    = '0;
    end else if (side_change) begin
      st_d.sel = sel_i;
      st_d.gap = !dt_zero;
      cnt_d    = dt_zero ? '0 : dt_i - 1'b1;
    end else if (st_q.gap) begin
      if (cnt_q == '0) begin
        st_d.gap = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '{sel: 1'b0, gap: 1'b1};
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign drv0_o = !st_q.gap && !st_q.sel;
  assign drv1_o = !st_q.gap &&  st_q.sel;
  assign sel_o  = st_q.sel;
  assign busy_o = st_q.gap;

endmodule

// File: rtl/psfb_phase_ctl.sv
module psfb_phase_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic trip_i,
  input  logic a_sel_i,
  input  logic a_busy_i,
  input  logic b_sel_i,
  input  logic b_busy_i,
  output logic a_tgt_o,
  output logic b_tgt_o
);

  logic ph_q, ph_d;
  logic bt_q, bt_d;
  logic a_settled, b_settled, armed, trip_ok;

  assign a_settled = !a_busy_i && (a_sel_i == ph_q);
  assign b_settled = !b_busy_i && (b_sel_i == bt_q);
  assign armed     = (bt_q == ph_q);
  assign trip_ok   = trip_i && armed && a_settled && b_settled;

  always_comb begin
    ph_d = ph_q;
    bt_d = bt_q;
    if (!en_i) begin
      ph_d = 1'b0;
      bt_d = 1'b0;
    end else if (start_i) begin
      ph_d = !ph_q;
      bt_d = !ph_q;
    end else if (trip_ok) begin
      bt_d = !bt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b0;
      bt_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      bt_q <= bt_d;
    end
  end

  assign a_tgt_o = ph_q;
  assign b_tgt_o = bt_q;

endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DT_W    = 6,
  parameter int DIS_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] chg_len_i,
  input  logic [DT_W-1:0]  dt_a_i,
  input  logic [DT_W-1:0]  dt_b_i,
  input  logic             mod_trip_i,
  input  logic             ilim_trip_i,
  output logic             a_hi_o,
  output logic             a_lo_o,
  output logic             b_hi_o,
  output logic             b_lo_o,
  output logic             osc_clk_o
);

  logic            osc_start;
  logic            trip_any;
  logic [DT_W-1:0] leg_dt   [NUM_LEGS];
  logic            leg_tgt  [NUM_LEGS];
  logic            leg_drv0 [NUM_LEGS];
  logic            leg_drv1 [NUM_LEGS];
  logic            leg_sel  [NUM_LEGS];
  logic            leg_busy [NUM_LEGS];

  assign trip_any      = mod_trip_i || ilim_trip_i;
  assign leg_dt[LEG_A] = dt_a_i;
  assign leg_dt[LEG_B] = dt_b_i;

  psfb_osc #(
    .CNT_W   (CNT_W),
    .DIS_CYC (DIS_CYC)
  ) u_osc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .chg_len_i (chg_len_i),
    .osc_clk_o (osc_clk_o),
    .start_o   (osc_start)
  );

  psfb_phase_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .start_i  (osc_start),
    .trip_i   (trip_any),
    .a_sel_i  (leg_sel[LEG_A]),
    .a_busy_i (leg_busy[LEG_A]),
    .b_sel_i  (leg_sel[LEG_B]),
    .b_busy_i (leg_busy[LEG_B]),
    .a_tgt_o  (leg_tgt[LEG_A]),
    .b_tgt_o  (leg_tgt[LEG_B])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(
      .DT_W (DT_W)
    ) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .sel_i  (leg_tgt[g]),
      .dt_i   (leg_dt[g]),
      .drv0_o (leg_drv0[g]),
      .drv1_o (leg_drv1[g]),
      .sel_o  (leg_sel[g]),
      .busy_o (leg_busy[g])
    );
  end

  // Leg A: select 0 = low side; leg B: select 0 = high side.
  assign a_lo_o = leg_drv0[LEG_A];
  assign a_hi_o = leg_drv1[LEG_A];
  assign b_hi_o = leg_drv0[LEG_B];
  assign b_lo_o = leg_drv1[LEG_B];

endmodule

// File: rtl/psfb_gate_seq_chk.sv
module psfb_gate_seq_chk #(
  parameter int DT_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [DT_W-1:0] dt_a_i,
  input logic            a_hi_o,
  input logic            a_lo_o,
  input logic            b_hi_o,
  input logic            b_lo_o,
  input logic            osc_clk_o
);

  AST_LEG_A_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_hi_o && a_lo_o)); // R9

  AST_LEG_B_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_hi_o && b_lo_o)); // R9

  AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o || osc_clk_o)); // R10

  AST_START_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> (a_lo_o && b_hi_o && !a_hi_o && !b_lo_o)); // R2

  AST_A_GAP_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(osc_clk_o) && en_i && (dt_a_i != '0)) |=> (!a_hi_o && !a_lo_o)); // R5

endmodule

bind psfb_gate_seq psfb_gate_seq_chk #(
  .DT_W (DT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .dt_a_i    (dt_a_i),
  .a_hi_o    (a_hi_o),
  .a_lo_o    (a_lo_o),
  .b_hi_o    (b_hi_o),
  .b_lo_o    (b_lo_o),
  .osc_clk_o (osc_clk_o)
);

// File: tb/test_psfb_gate_seq.sv
module test_psfb_gate_seq;

  localparam int CNT_W   = 8;
  localparam int DT_W    = 6;
  localparam int DIS_CYC = 4;

  // Vector order: {a_hi, a_lo, b_hi, b_lo, osc_clk}
  typedef struct {
    int         cyc;
    logic [4:0] vec;
    string      tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             en_i;
  logic [CNT_W-1:0] chg_len_i;
  logic [DT_W-1:0]  dt_a_i, dt_b_i;
  logic             mod_trip_i, ilim_trip_i;
  logic             a_hi_o, a_lo_o, b_hi_o, b_lo_o, osc_clk_o;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk_i = !clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  psfb_gate_seq #(
    .CNT_W   (CNT_W),
    .DT_W    (DT_W),
    .DIS_CYC (DIS_CYC)
  ) i_psfb_gate_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .chg_len_i   (chg_len_i),
    .dt_a_i      (dt_a_i),
    .dt_b_i      (dt_b_i),
    .mod_trip_i  (mod_trip_i),
    .ilim_trip_i (ilim_trip_i),
    .a_hi_o      (a_hi_o),
    .a_lo_o      (a_lo_o),
    .b_hi_o      (b_hi_o),
    .b_lo_o      (b_lo_o),
    .osc_clk_o   (osc_clk_o)
  );

  task automatic expect_at(input int c, input logic [4:0] v, input string tag);
    exp_t e;
    e.cyc = c; e.vec = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic goto(input int n);
    @(negedge clk_i);
    while (cyc < n) @(negedge clk_i);
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni === 1'b1) begin
        checks++;
        if ((a_hi_o && a_lo_o) || (b_hi_o && b_lo_o)) begin
          fails++;
          $display("FAIL R9 cyc=%0d actual=%b expected no leg overlap", cyc,
                   {a_hi_o, a_lo_o, b_hi_o, b_lo_o});
        end
      end
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        logic [4:0] act;
        e = q.pop_front();
        act = {a_hi_o, a_lo_o, b_hi_o, b_lo_o, osc_clk_o};
        checks++;
        if (e.cyc != cyc || act !== e.vec) begin
          fails++;
          $display("FAIL %s cyc=%0d(exp cyc %0d) actual=%b expected=%b",
                   e.tag, cyc, e.cyc, act, e.vec);
        end
      end
    end
  end

  // Driver
  initial begin
    rst_ni = 1'b0; en_i = 1'b0; chg_len_i = 8'd10;
    dt_a_i = 6'd3; dt_b_i = 6'd2; mod_trip_i = 1'b0; ilim_trip_i = 1'b0;
    goto(2);
    rst_ni = 1'b1;

    expect_at(4,  5'b00000, "R1");
    expect_at(6,  5'b01100, "R2");
    expect_at(14, 5'b01100, "R3");
    expect_at(15, 5'b01101, "R3");
    expect_at(16, 5'b00001, "R5_R8");
    expect_at(17, 5'b00001, "R6");
    expect_at(18, 5'b00011, "R6");
    expect_at(19, 5'b10010, "R12_R3");
    expect_at(28, 5'b10010, "R3");
    expect_at(29, 5'b10011, "R3");
    expect_at(30, 5'b00001, "R8");
    expect_at(32, 5'b00101, "R6");
    expect_at(33, 5'b01100, "R12");
    expect_at(36, 5'b01000, "R4");
    expect_at(37, 5'b01000, "R4");
    expect_at(38, 5'b01010, "R4");
    expect_at(41, 5'b01010, "R11");
    expect_at(42, 5'b01010, "R11");
    expect_at(43, 5'b01011, "R5");
    expect_at(44, 5'b00011, "R5");
    expect_at(47, 5'b10010, "R11");
    expect_at(48, 5'b10010, "R11");
    expect_at(57, 5'b10011, "R8");
    expect_at(58, 5'b00001, "R8");
    expect_at(60, 5'b00101, "R8");
    expect_at(61, 5'b01100, "R12");
    goto(5);
    en_i = 1'b1;

    goto(34); mod_trip_i = 1'b1;                     // accepted, R4
    goto(35); mod_trip_i = 1'b0;
    goto(36); ilim_trip_i = 1'b1;                    // in B gap, R11
    goto(37); ilim_trip_i = 1'b0;
    goto(39); mod_trip_i = 1'b1;                     // already taken, R11
    goto(40); mod_trip_i = 1'b0;
    goto(44); ilim_trip_i = 1'b1;                    // in A gap, R11
    goto(45); ilim_trip_i = 1'b0;

    expect_at(71, 5'b01101, "R7");
    expect_at(72, 5'b10011, "R7");
    expect_at(74, 5'b10011, "R7");
    expect_at(75, 5'b10100, "R7_R4");
    expect_at(77, 5'b00000, "R10");
    expect_at(78, 5'b00000, "R10");
    expect_at(80, 5'b01100, "R10");
    expect_at(84, 5'b01100, "R3");
    expect_at(85, 5'b01101, "R3");
    expect_at(86, 5'b10011, "R7");
    expect_at(88, 5'b10011, "R3");
    expect_at(89, 5'b10010, "R3");
    expect_at(94, 5'b10010, "R3");
    expect_at(95, 5'b10011, "R3");
    goto(62); dt_a_i = 6'd0; dt_b_i = 6'd0;
    goto(73); mod_trip_i = 1'b1;
    goto(74); mod_trip_i = 1'b0;
    goto(76); en_i = 1'b0;
    goto(78); chg_len_i = 8'd6;
    goto(79); en_i = 1'b1;
    goto(97);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3 unchecked items=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule